// File: doc/BRIEF.md
# Configurable Parallel Pin Bus Host

This block serves single read and write requests from an internal valid/ready interface by running them as strobed transactions on a 32-pin shared parallel bus. A configuration word sets four things: the address width, the data width, whether reads and writes take one cycle or two, and whether narrow data moves to the upper byte lanes. Address and data share the one pin vector. Where each field lands depends on the widths chosen. The configuration is checked for legality. Any pins it leaves free are reported on a mask so that other functions can take them.

The sequencer has seven states. S_IDLE waits for a request. A one-cycle write passes through S_WR_ONE. A two-cycle write passes through S_WR_ADDR and then S_WR_DATA. A one-cycle read passes through S_RD_ONE. A two-cycle read passes through S_RD_ADDR and then S_RD_CAPT. The transitions are as follows:
- From S_IDLE, an accepted write goes to S_WR_ADDR when two-cycle writes are on, and to S_WR_ONE otherwise.
- From S_IDLE, an accepted read goes to S_RD_ADDR when two-cycle reads are on, and to S_RD_ONE otherwise.
- S_WR_ADDR always moves to S_WR_DATA.
- S_RD_ADDR always moves to S_RD_CAPT.
- S_WR_ONE, S_WR_DATA, S_RD_ONE and S_RD_CAPT each return to S_IDLE.

Read data is sampled on the clock edge that leaves S_RD_ONE or S_RD_CAPT. It is presented with a one-cycle response pulse.

Top module: `pbus_host`

## Requirements
- R1: After reset the block is in S_IDLE with the following outputs: bus_rd=0, bus_wr=0, bus_oe=0, bus_out=0, rsp_valid=0, cfg_err=0 and req_ready=1. The configuration is no address, 8-bit data, one-cycle timing and word mode off, so unused_mask=32'hFFFF_FF00.
- R2: cfg_asize selects the address width as follows:
  - code 0: no address;
  - code 1: addr[3:0] on pins [27:24];
  - code 2: addr[11:0] on pins [27:16];
  - code 3: addr[19:0] on pins [27:8].
- R3: cfg_dsize selects the data width. Codes 0, 1, 2 and 3 mean 8, 16, 24 and 32 bits. With word mode off, data occupies pins [7:0], [15:0], [23:0] or [31:0]. Read data returns zero-extended on rsp_rdata.
- R4: With cfg_word=1, 8-bit data uses pins [31:24] and 16-bit data uses pins [31:16]. Word mode has no effect on 24-bit or 32-bit data.
- R5: A configuration is illegal in either of these cases:
  - its address pins overlap its data pins (this forbids 32-bit data with any address, 24-bit data with a 12-bit or 20-bit address, 16-bit data with a 20-bit address, and word mode with any address while the data is 8 or 16 bits);
  - it selects 32-bit data with both cfg_rd2 and cfg_wr2 clear.
- R6: cfg_err shows, from the cycle after a configuration write, whether that configuration was illegal. It holds its value until the next accepted configuration write.
- R7: A one-cycle write (cfg_wr2=0) raises bus_wr for one cycle with address and data driven together, then returns to idle.
- R8: A two-cycle write raises bus_wr in its first cycle with only the address driven. In its second cycle bus_wr is low and only the data is driven.
- R9: A one-cycle read raises bus_rd for one cycle with the address driven and samples bus_in at the end of that cycle. rsp_valid pulses in the next cycle carrying that data.
- R10: A two-cycle read raises bus_rd in cycle one. In cycle two bus_rd is low and the address is still driven. bus_in is sampled at the end of cycle two, and rsp_valid pulses in the following cycle.
- R11: dir_mode equals cfg_rw OR cfg_rd2 OR cfg_wr2, taken from the stored configuration.
- R12: unused_mask is the complement of the address and data pins of the stored configuration. bus_oe never sets a bit in unused_mask, and bus_out is 0 wherever bus_oe is 0.
- R13: req_ready is high only in S_IDLE when cfg_err=0 and cfg_we=0. A configuration write made while a transaction is in flight is ignored.
- R14: bus_rd and bus_wr are never high together. While cfg_err=1, a pending request produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_asize | input | 2 | Address width code |
| cfg_dsize | input | 2 | Data width code |
| cfg_rd2 | input | 1 | Two-cycle read enable |
| cfg_wr2 | input | 1 | Two-cycle write enable |
| cfg_word | input | 1 | Upper-lane word mode |
| cfg_rw | input | 1 | Direction indicator request |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data, zero-extended |
| cfg_err | output | 1 | Sticky illegal-configuration flag |
| dir_mode | output | 1 | Effective direction indicator |
| unused_mask | output | 32 | Pins free for other uses |
| bus_out | output | 32 | Pin output values |
| bus_oe | output | 32 | Pin output enables |
| bus_in | input | 32 | Pin input values |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |

## Verification
Two situations are hard to reach from the ports. One is a configuration write that lands while a two-cycle write is in flight. The bench raises cfg_we in the address cycle with an illegal setting. It then checks that the data phase, cfg_err and unused_mask all still reflect the old setting. The other is showing that a two-cycle read samples in its second cycle and not in its first. The bench drives a decoy value on bus_in during the strobe cycle and the real value only in the capture cycle, and it checks this across random legal width, timing and word-mode combinations.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 20;

    typedef enum logic [1:0] {ASZ_NONE, ASZ_4, ASZ_12, ASZ_20} asize_e;
    typedef enum logic [1:0] {DSZ_8, DSZ_16, DSZ_24, DSZ_32}   dsize_e;

    typedef struct packed {
        asize_e asz;
        dsize_e dsz;
        logic   rd2;
        logic   wr2;
        logic   word;
        logic   rw;
    } cfg_t;

    localparam cfg_t CFG_RST = '{asz: ASZ_NONE, dsz: DSZ_8, rd2: 1'b0,
                                 wr2: 1'b0, word: 1'b0, rw: 1'b0};

    typedef enum logic [2:0] {
        S_IDLE, S_WR_ONE, S_WR_ADDR, S_WR_DATA, S_RD_ONE, S_RD_ADDR, S_RD_CAPT
    } state_e;

    // pins carrying the address for a width code
    function automatic logic [BUS_W-1:0] addr_pins(asize_e a);
        logic [BUS_W-1:0] m;
        case (a)
            ASZ_4:   m = 32'h0F00_0000;
            ASZ_12:  m = 32'h0FFF_0000;
            ASZ_20:  m = 32'h0FFF_FF00;
            default: m = '0;
        endcase
        return m;
    endfunction

    // pins carrying data for a width code and lane mode
    function automatic logic [BUS_W-1:0] data_pins(dsize_e d, logic w);
        logic [BUS_W-1:0] m;
        case (d)
            DSZ_8:   m = w ? 32'hFF00_0000 : 32'h0000_00FF;
            DSZ_16:  m = w ? 32'hFFFF_0000 : 32'h0000_FFFF;
            DSZ_24:  m = 32'h00FF_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    function automatic logic cfg_legal(cfg_t c);
        logic ok;
        ok = ((addr_pins(c.asz) & data_pins(c.dsz, c.word)) == '0);
        if (c.dsz == DSZ_32 && !(c.rd2 || c.wr2)) ok = 1'b0;
        return ok;
    endfunction
endpackage

// File: rtl/pbus_cfg.sv
module pbus_cfg
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  cfg_t             cfg_in,
    output cfg_t             cfg_q,
    output logic             err_q,
    output logic             dir_mode,
    output logic [BUS_W-1:0] unused_mask
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
            err_q <= 1'b0;
        end else if (cfg_load) begin
            cfg_q <= cfg_in;
            err_q <= !cfg_legal(cfg_in);
        end
    end

    always_comb begin
        dir_mode    = cfg_q.rw | cfg_q.rd2 | cfg_q.wr2;
        unused_mask = ~(addr_pins(cfg_q.asz) | data_pins(cfg_q.dsz, cfg_q.word));
    end

    // R6: the error flag moves only on an accepted configuration write
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> (err_q == $past(err_q)));
endmodule

// File: rtl/pbus_lanes.sv
module pbus_lanes
    import pbus_pkg::*;
(
    input  asize_e            asz,
    input  dsize_e            dsz,
    input  logic              word,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  pins_in,
    output logic [BUS_W-1:0]  addr_field,
    output logic [BUS_W-1:0]  addr_mask,
    output logic [BUS_W-1:0]  data_field,
    output logic [BUS_W-1:0]  data_mask,
    output logic [BUS_W-1:0]  rd_lane
);
    always_comb begin
        addr_mask = addr_pins(asz);
        data_mask = data_pins(dsz, word);
        unique case (asz)
            ASZ_NONE: addr_field = '0;
            ASZ_4:    addr_field = {4'h0, addr[3:0], 24'h0};
            ASZ_12:   addr_field = {4'h0, addr[11:0], 16'h0};
            ASZ_20:   addr_field = {4'h0, addr[19:0], 8'h0};
            default:  addr_field = '0;
        endcase
        unique case (dsz)
            DSZ_8: begin
                data_field = word ? {wdata[7:0], 24'h0} : {24'h0, wdata[7:0]};
                rd_lane    = word ? {24'h0, pins_in[31:24]} : {24'h0, pins_in[7:0]};
            end
            DSZ_16: begin
                data_field = word ? {wdata[15:0], 16'h0} : {16'h0, wdata[15:0]};
                rd_lane    = word ? {16'h0, pins_in[31:16]} : {16'h0, pins_in[15:0]};
            end
            DSZ_24: begin
                data_field = {8'h0, wdata[23:0]};
                rd_lane    = {8'h0, pins_in[23:0]};
            end
            default: begin
                data_field = wdata;
                rd_lane    = pins_in;
            end
        endcase
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    input  logic              cfg_we,
    input  logic              err,
    input  logic              rd2,
    input  logic              wr2,
    input  logic [BUS_W-1:0]  addr_field,
    input  logic [BUS_W-1:0]  addr_mask,
    input  logic [BUS_W-1:0]  data_field,
    input  logic [BUS_W-1:0]  data_mask,
    input  logic [BUS_W-1:0]  rd_lane,
    output logic              req_ready,
    output logic              idle,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [BUS_W-1:0]  lat_wdata,
    output logic [BUS_W-1:0]  bus_out,
    output logic [BUS_W-1:0]  bus_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_rdata
);
    state_e state_q, state_d;
    logic   accept, capture;

    assign idle      = (state_q == S_IDLE);
    assign req_ready = idle && !err && !cfg_we;
    assign accept    = req_valid && req_ready;
    assign capture   = (state_q == S_RD_ONE) || (state_q == S_RD_CAPT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) begin
                if (req_write) state_d = wr2 ? S_WR_ADDR : S_WR_ONE;
                else           state_d = rd2 ? S_RD_ADDR : S_RD_ONE;
            end
            S_WR_ADDR: state_d = S_WR_DATA;
            S_RD_ADDR: state_d = S_RD_CAPT;
            S_WR_ONE, S_WR_DATA, S_RD_ONE, S_RD_CAPT: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            rsp_valid <= capture;
            if (capture) rsp_rdata <= rd_lane;
        end
    end

    always_comb begin
        bus_out = '0;
        bus_oe  = '0;
        bus_rd  = 1'b0;
        bus_wr  = 1'b0;
        unique case (state_q)
            S_WR_ONE: begin
                bus_wr  = 1'b1;
                bus_out = addr_field | data_field;
                bus_oe  = addr_mask | data_mask;
            end
            S_WR_ADDR: begin
                bus_wr  = 1'b1;
                bus_out = addr_field;
                bus_oe  = addr_mask;
            end
            S_WR_DATA: begin
                bus_out = data_field;
                bus_oe  = data_mask;
            end
            S_RD_ONE, S_RD_ADDR: begin
                bus_rd  = 1'b1;
                bus_out = addr_field;
                bus_oe  = addr_mask;
            end
            S_RD_CAPT: begin
                bus_out = addr_field;
                bus_oe  = addr_mask;
            end
            default: ;
        endcase
    end

    // R8: the data phase of a write always follows its address phase
    a_r8_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_DATA) |-> ($past(state_q) == S_WR_ADDR));
    // R10: the capture cycle of a read always follows its strobe cycle
    a_r10_capt_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_CAPT) |-> ($past(state_q) == S_RD_ADDR));
    // R9: a response appears only one cycle after a capture state
    a_r9_rsp_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(state_q) == S_RD_ONE || $past(state_q) == S_RD_CAPT));
endmodule

// File: rtl/pbus_host.sv
module pbus_host
    import pbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_asize,
    input  logic [1:0]  cfg_dsize,
    input  logic        cfg_rd2,
    input  logic        cfg_wr2,
    input  logic        cfg_word,
    input  logic        cfg_rw,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [19:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        cfg_err,
    output logic        dir_mode,
    output logic [31:0] unused_mask,
    output logic [31:0] bus_out,
    output logic [31:0] bus_oe,
    input  logic [31:0] bus_in,
    output logic        bus_rd,
    output logic        bus_wr
);
    cfg_t              cfg_in, cfg_q;
    logic              idle, cfg_load;
    logic [ADDR_W-1:0] lat_addr;
    logic [BUS_W-1:0]  lat_wdata, addr_field, addr_mask, data_field, data_mask, rd_lane;

    assign cfg_in   = '{asz: asize_e'(cfg_asize), dsz: dsize_e'(cfg_dsize),
                        rd2: cfg_rd2, wr2: cfg_wr2, word: cfg_word, rw: cfg_rw};
    assign cfg_load = cfg_we && idle;

    pbus_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_in(cfg_in),
        .cfg_q(cfg_q), .err_q(cfg_err), .dir_mode(dir_mode), .unused_mask(unused_mask)
    );

    pbus_lanes u_lanes (
        .asz(cfg_q.asz), .dsz(cfg_q.dsz), .word(cfg_q.word),
        .addr(lat_addr), .wdata(lat_wdata), .pins_in(bus_in),
        .addr_field(addr_field), .addr_mask(addr_mask),
        .data_field(data_field), .data_mask(data_mask), .rd_lane(rd_lane)
    );

    pbus_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_we(cfg_we), .err(cfg_err),
        .rd2(cfg_q.rd2), .wr2(cfg_q.wr2),
        .addr_field(addr_field), .addr_mask(addr_mask),
        .data_field(data_field), .data_mask(data_mask), .rd_lane(rd_lane),
        .req_ready(req_ready), .idle(idle), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // R12: enabled pins stay inside the pins the configuration claims
    a_r12_oe_within_used: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe & unused_mask) == '0);
    // R12: undriven pins carry zero
    a_r12_out_zero_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_out & ~bus_oe) == '0);
    // R14: the strobes are exclusive
    a_r14_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R14: an error blocks every strobe
    a_r14_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err) && idle) |=> !(bus_rd || bus_wr));
endmodule

// File: tb/pbus_host_bench.sv
module pbus_host_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_rd2 = 1'b0, cfg_wr2 = 1'b0, cfg_word = 1'b0, cfg_rw = 1'b0;
    logic [1:0]  cfg_asize = '0, cfg_dsize = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0, bus_in = '0;
    logic        req_ready, rsp_valid, cfg_err, dir_mode, bus_rd, bus_wr;
    logic [31:0] rsp_rdata, unused_mask, bus_out, bus_oe;

    int n_cmp = 0;
    int n_mis = 0;

    // model of the stored configuration
    logic [1:0] m_asz = '0, m_dsz = '0;
    logic       m_rd2 = 1'b0, m_wr2 = 1'b0, m_word = 1'b0, m_rw = 1'b0, m_err = 1'b0;

    always #10 clk = ~clk;

    pbus_host u_pbus_host (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_asize(cfg_asize),
        .cfg_dsize(cfg_dsize), .cfg_rd2(cfg_rd2), .cfg_wr2(cfg_wr2), .cfg_word(cfg_word),
        .cfg_rw(cfg_rw), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_err(cfg_err),
        .dir_mode(dir_mode), .unused_mask(unused_mask), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_in(bus_in), .bus_rd(bus_rd), .bus_wr(bus_wr)
    );

    function automatic logic [31:0] f_amask(logic [1:0] a);
        case (a)
            2'd1:    return 32'h0F00_0000;
            2'd2:    return 32'h0FFF_0000;
            2'd3:    return 32'h0FFF_FF00;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] f_afield(logic [1:0] a, logic [19:0] ad);
        case (a)
            2'd1:    return {4'h0, ad[3:0], 24'h0};
            2'd2:    return {4'h0, ad[11:0], 16'h0};
            2'd3:    return {4'h0, ad, 8'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] f_dmask(logic [1:0] d, logic w);
        case (d)
            2'd0:    return w ? 32'hFF00_0000 : 32'h0000_00FF;
            2'd1:    return w ? 32'hFFFF_0000 : 32'h0000_FFFF;
            2'd2:    return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] f_dfield(logic [1:0] d, logic w, logic [31:0] v);
        int sh;
        logic [31:0] lo;
        lo = v & ((d == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (d + 1))) - 1));
        sh = (w && d < 2'd2) ? (32 - 8 * (d + 1)) : 0;
        return lo << sh;
    endfunction

    function automatic logic [31:0] f_extract(logic [1:0] d, logic w, logic [31:0] p);
        int sh;
        logic [31:0] m;
        m  = (d == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (d + 1))) - 1);
        sh = (w && d < 2'd2) ? (32 - 8 * (d + 1)) : 0;
        return (p >> sh) & m;
    endfunction

    function automatic logic f_legal(logic [1:0] a, logic [1:0] d, logic r2, logic w2, logic w);
        if ((f_amask(a) & f_dmask(d, w)) != 0) return 1'b0;
        if (d == 2'd3 && !(r2 || w2)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(string tag);
        chk({tag, " R1 rd idle"}, {31'h0, bus_rd}, 32'h0);
        chk({tag, " R1 wr idle"}, {31'h0, bus_wr}, 32'h0);
        chk({tag, " R12 oe idle"}, bus_oe, 32'h0);
        chk({tag, " R13 ready idle"}, {31'h0, req_ready}, {31'h0, !m_err});
    endtask

    task automatic cfg_write(logic [1:0] a, logic [1:0] d, logic r2, logic w2, logic w, logic rw);
        @(negedge clk);
        cfg_asize = a; cfg_dsize = d; cfg_rd2 = r2; cfg_wr2 = w2; cfg_word = w; cfg_rw = rw;
        cfg_we = 1'b1;
        #2;
        chk("R13 ready low during cfg_we", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        m_asz = a; m_dsz = d; m_rd2 = r2; m_wr2 = w2; m_word = w; m_rw = rw;
        m_err = !f_legal(a, d, r2, w2, w);
        #2;
        chk("R5 R6 cfg_err", {31'h0, cfg_err}, {31'h0, m_err});
        chk("R13 ready after cfg", {31'h0, req_ready}, {31'h0, !m_err});
        chk("R12 unused_mask", unused_mask, ~(f_amask(a) | f_dmask(d, w)));
        chk("R11 dir_mode", {31'h0, dir_mode}, {31'h0, rw | r2 | w2});
    endtask

    task automatic do_write(logic [19:0] ad, logic [31:0] v);
        logic [31:0] af, dfv, am, dm;
        af = f_afield(m_asz, ad); am = f_amask(m_asz);
        dfv = f_dfield(m_dsz, m_word, v); dm = f_dmask(m_dsz, m_word);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ad; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~v; req_addr = ~ad;
        if (!m_wr2) begin
            chk("R7 wr strobe", {31'h0, bus_wr}, 32'h1);
            chk("R7 R2 R3 R4 pins", bus_out, af | dfv);
            chk("R7 oe", bus_oe, am | dm);
        end else begin
            chk("R8 wr strobe c1", {31'h0, bus_wr}, 32'h1);
            chk("R8 R2 addr c1", bus_out, af);
            chk("R8 oe c1", bus_oe, am);
            @(negedge clk);
            chk("R8 wr low c2", {31'h0, bus_wr}, 32'h0);
            chk("R8 R3 R4 data c2", bus_out, dfv);
            chk("R8 oe c2", bus_oe, dm);
        end
        @(negedge clk);
        chk_idle("after write");
    endtask

    task automatic do_read(logic [19:0] ad, logic [31:0] pv);
        logic [31:0] af, am;
        af = f_afield(m_asz, ad); am = f_amask(m_asz);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ad;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~ad;
        if (!m_rd2) begin
            bus_in = pv;
            chk("R9 rd strobe", {31'h0, bus_rd}, 32'h1);
            chk("R9 R2 addr", bus_out, af);
            chk("R9 oe", bus_oe, am);
        end else begin
            bus_in = ~pv;
            chk("R10 rd strobe c1", {31'h0, bus_rd}, 32'h1);
            chk("R10 R2 addr c1", bus_out, af);
            @(negedge clk);
            bus_in = pv;
            chk("R10 rd low c2", {31'h0, bus_rd}, 32'h0);
            chk("R10 addr held c2", bus_out, af);
            chk("R10 oe c2", bus_oe, am);
            chk("R10 no early rsp", {31'h0, rsp_valid}, 32'h0);
        end
        @(negedge clk);
        bus_in = $urandom;
        chk("R9 R10 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        chk("R3 R4 rsp_rdata", rsp_rdata, f_extract(m_dsz, m_word, pv));
        @(negedge clk);
        chk("R9 rsp pulse ends", {31'h0, rsp_valid}, 32'h0);
        chk_idle("after read");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_mis++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_idle("R1 reset");
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R1 bus_out", bus_out, 32'h0);
        chk("R1 cfg_err", {31'h0, cfg_err}, 32'h0);
        chk("R1 unused_mask", unused_mask, 32'hFFFF_FF00);
        do_write(20'h12345, 32'hDEAD_BEEF);
        do_read(20'h0, 32'h1234_56A5);

        // R5 directed illegal combinations
        cfg_write(2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0); // 32-bit with address
        cfg_write(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0); // 32-bit, one-cycle
        cfg_write(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0); // 24-bit, 12-bit addr
        cfg_write(2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0); // 16-bit, 20-bit addr
        cfg_write(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0); // word mode with addr

        // R6 R14 sticky error blocks requests
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R14 no wr under err", {31'h0, bus_wr}, 32'h0);
            chk("R14 no rd under err", {31'h0, bus_rd}, 32'h0);
            chk("R6 err held", {31'h0, cfg_err}, 32'h1);
            chk("R13 ready low under err", {31'h0, req_ready}, 32'h0);
        end
        req_valid = 1'b0;

        // legal corner cases
        cfg_write(2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        do_read(20'h0, 32'h89AB_CDEF);
        do_write(20'h0, 32'h0BAD_F00D);
        cfg_write(2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        do_write(20'hFFFFA, 32'hCAFE_1234);
        cfg_write(2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        do_read(20'hABCDE, 32'h0000_0077);
        cfg_write(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        do_write(20'h0, 32'h0000_00C3);
        do_read(20'h0, 32'h5A00_0000);
        cfg_write(2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        do_read(20'h0, 32'hBEEF_0000);
        do_write(20'h0, 32'h1111_2222);

        // R13 configuration write during a two-cycle write is ignored
        cfg_write(2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00ABC; req_wdata = 32'h0000_005E;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_asize = 2'd3; cfg_dsize = 2'd3; cfg_rd2 = 1'b0; cfg_wr2 = 1'b0; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R13 data phase kept", bus_out, 32'h0000_005E);
        @(negedge clk);
        chk("R13 busy cfg ignored err", {31'h0, cfg_err}, 32'h0);
        chk("R13 busy cfg ignored mask", unused_mask, ~(f_amask(2'd2) | f_dmask(2'd0, 1'b0)));

        // random configurations and transactions
        for (int it = 0; it < 300; it++) begin
            logic [1:0] a, d;
            logic r2, w2, w, rw;
            a = 2'($urandom); d = 2'($urandom);
            r2 = 1'($urandom); w2 = 1'($urandom); w = 1'($urandom); rw = 1'($urandom);
            if ((it % 3) != 0 && !f_legal(a, d, r2, w2, w)) a = 2'd0;
            if ((it % 3) != 0 && !f_legal(a, d, r2, w2, w)) r2 = 1'b1;
            cfg_write(a, d, r2, w2, w, rw);
            if (!m_err) begin
                for (int k = 0; k < 2; k++) begin
                    if ($urandom % 2 == 0) do_write(20'($urandom), $urandom);
                    else                   do_read(20'($urandom), $urandom);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule